// File: doc/BRIEF.md
# Self-Triggered Segment Capture Pool

This block manages a pool of short capture segments for a front end that should lose almost no events to dead time. A self-trigger pulse claims a free segment and stamps it with the value of a free-running coarse counter. The segment then fills for one full segment length, which is one cycle per sampling cell, and joins a first-in first-out readout queue. A reader takes segments from the head of that queue and streams them out while further triggers fill other segments at the same time.

Each readout beat carries the segment number, its coarse timestamp and a sample index. A segment returns to the free pool only after its last beat has been accepted downstream. A trigger that arrives while every segment is in use is dropped and counted. A level flag tells downstream logic that filled data is waiting, so the readout is driven by the data and not polled.

The output is a valid/ready stream. A beat is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field holds its value. `out_valid` never falls before the beat has been transferred. Downstream may hold `out_ready` low for any length of time. Writing into other free segments continues while the stream is stalled.

Top module: `segcap_top`

## Requirements
- R1: After synchronous reset `rst`, `out_valid` is 0, `data_ready` is 0 and `ovf_count` is 0, and all `N_SEG` segments are free.
- R2: A `trig_in` pulse seen while no segment is filling and at least one segment is free claims the lowest-numbered free segment, with numbers running from 0 to `N_SEG`-1.
- R3: A claimed segment fills for `CELLS` cycles (32 by default). It becomes visible on `data_ready` 32 cycles after the triggering edge. Triggers that arrive while a segment is filling have no effect: no segment is claimed and `ovf_count` does not change.
- R4: A trigger that arrives while no segment is filling and no segment is free is discarded, and `ovf_count` rises by one. The counter saturates at its maximum value.
- R5: A segment's timestamp is the value of a free-running `TS_W`-bit counter at the triggering edge. The counter advances by one every cycle and wraps modulo 2^`TS_W`, so two triggers D cycles apart carry timestamps that differ by D mod 2^`TS_W`.
- R6: Filled segments are read out in the order in which they were triggered.
- R7: Each segment is streamed as `RD_N` beats with `out_idx` running 0, 1, …, `RD_N`-1. `out_last` is high only on the final beat, and `out_seg` and `out_ts` are constant across all beats of the segment.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_idx`, `out_seg`, `out_ts` and `out_last` all hold their values on the next cycle.
- R9: A segment becomes free again only after its last beat is transferred. New segments can be claimed and filled while another segment is being read.
- R10: `data_ready` is high whenever at least one filled segment has not yet been completely read out, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Self-trigger pulse, sampled on each rising edge |
| data_ready | output | 1 | Filled data is waiting or being read |
| ovf_count | output | OVF_W | Saturating count of triggers dropped because no segment was free |
| out_valid | output | 1 | Readout beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_seg | output | $clog2(N_SEG) | Segment number of the beat |
| out_ts | output | TS_W | Coarse timestamp of the segment |
| out_idx | output | $clog2(RD_N) | Sample index within the segment |
| out_last | output | 1 | Final beat of the segment |

## Verification
Triggers are issued at a range of spacings. A single isolated trigger checks the 32-cycle fill latency exactly. A second trigger during the fill separates "ignored" from "queued". A 50-cycle gap and a 300-cycle gap separate a correct modulo timestamp difference from an absolute or non-wrapping one. Readout is exercised with `out_ready` always high, alternating and one-in-three, so that field stability under stall can be told apart from beat skipping or duplication. Filling every segment with readout stalled, then adding another trigger, separates discarding from overwriting. Re-triggering straight after one segment drains shows that a segment is freed at its last beat and not earlier, and that the queue order stays tied to trigger order.

// File: rtl/segcap_pkg.sv
package segcap_pkg;
  typedef enum logic [0:0] {
    WR_IDLE = 1'b0,
    WR_FILL = 1'b1
  } wr_state_t;
endpackage

// File: rtl/segcap_free_pool.sv
module segcap_free_pool #(
  parameter int N_SEG = 4,
  parameter int ID_W  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_req,
  input  logic            rel_en,
  input  logic [ID_W-1:0] rel_id,
  output logic            any_free,
  output logic [ID_W-1:0] alloc_id
);
  logic [N_SEG-1:0] free_q;

  // lowest-numbered free entry wins
  always_comb begin
    any_free = |free_q;
    alloc_id = '0;
    for (int i = N_SEG - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_id = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= '1;
    end else begin
      if (alloc_req) free_q[alloc_id] <= 1'b0;
      if (rel_en)    free_q[rel_id]   <= 1'b1;
    end
  end

  assert_alloc_has_free_R2: assert property (@(posedge clk) disable iff (rst)
    alloc_req |-> any_free);

  assert_release_busy_only_R9: assert property (@(posedge clk) disable iff (rst)
    rel_en |-> !free_q[rel_id]);
endmodule

// File: rtl/segcap_order_fifo.sv
module segcap_order_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/segcap_reader.sv
module segcap_reader #(
  parameter int RD_N   = 20,
  parameter int ID_W   = 2,
  parameter int TS_W   = 8,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic [ID_W-1:0]   head_id,
  input  logic [TS_W-1:0]   head_ts,
  output logic              pop,
  output logic              busy,
  output logic              rel_en,
  output logic [ID_W-1:0]   rel_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_seg,
  output logic [TS_W-1:0]   out_ts,
  output logic [RIDX_W-1:0] out_idx,
  output logic              out_last
);
  logic vld;

  assign out_valid = vld;
  assign busy      = vld;
  assign out_last  = vld && (out_idx == RIDX_W'(RD_N - 1));
  assign pop       = !vld && head_valid;
  assign rel_en    = vld && out_ready && out_last;
  assign rel_id    = out_seg;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= 1'b0;
      out_idx <= '0;
      out_seg <= '0;
      out_ts  <= '0;
    end else if (!vld) begin
      if (head_valid) begin
        vld     <= 1'b1;
        out_idx <= '0;
        out_seg <= head_id;
        out_ts  <= head_ts;
      end
    end else if (out_ready) begin
      if (out_last) vld <= 1'b0;
      else          out_idx <= out_idx + 1'b1;
    end
  end

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) &&
                                   $stable(out_seg) && $stable(out_ts)));

  assert_index_steps_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1 && $stable(out_seg)));
endmodule

// File: rtl/segcap_top.sv
module segcap_top #(
  parameter int N_SEG  = 4,
  parameter int CELLS  = 32,
  parameter int RD_N   = 20,
  parameter int TS_W   = 8,
  parameter int OVF_W  = 8,
  localparam int ID_W   = (N_SEG > 1) ? $clog2(N_SEG) : 1,
  localparam int RIDX_W = $clog2(RD_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_in,
  output logic              data_ready,
  output logic [OVF_W-1:0]  ovf_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_seg,
  output logic [TS_W-1:0]   out_ts,
  output logic [RIDX_W-1:0] out_idx,
  output logic              out_last
);
  import segcap_pkg::*;

  localparam int CW = $clog2(CELLS);
  localparam int QW = ID_W + TS_W;

  wr_state_t         st;
  logic [CW-1:0]     wcnt;
  logic [ID_W-1:0]   wid;
  logic [TS_W-1:0]   wts;
  logic [TS_W-1:0]   ts_cnt;

  logic              any_free, accept, drop, push;
  logic [ID_W-1:0]   alloc_id;
  logic              q_empty, q_full, q_pop, rd_busy, rel_en;
  logic [ID_W-1:0]   rel_id;
  logic [QW-1:0]     q_head;

  assign accept = trig_in && (st == WR_IDLE) && any_free;
  assign drop   = trig_in && (st == WR_IDLE) && !any_free;
  assign push   = (st == WR_FILL) && (wcnt == CW'(CELLS - 1));

  always_ff @(posedge clk) begin
    if (rst) ts_cnt <= '0;
    else     ts_cnt <= ts_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= WR_IDLE;
      wcnt <= '0;
      wid  <= '0;
      wts  <= '0;
    end else begin
      case (st)
        WR_IDLE: if (accept) begin
          st   <= WR_FILL;
          wcnt <= '0;
          wid  <= alloc_id;
          wts  <= ts_cnt;
        end
        WR_FILL: begin
          if (push) st <= WR_IDLE;
          else      wcnt <= wcnt + 1'b1;
        end
        default: st <= WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        ovf_count <= '0;
    else if (drop && ~&ovf_count)   ovf_count <= ovf_count + 1'b1;
  end

  segcap_free_pool #(.N_SEG(N_SEG), .ID_W(ID_W)) u_pool (
    .clk(clk), .rst(rst), .alloc_req(accept), .rel_en(rel_en),
    .rel_id(rel_id), .any_free(any_free), .alloc_id(alloc_id)
  );

  segcap_order_fifo #(.DEPTH(N_SEG), .W(QW)) u_queue (
    .clk(clk), .rst(rst), .push(push), .din({wid, wts}), .pop(q_pop),
    .dout(q_head), .empty(q_empty), .full(q_full)
  );

  segcap_reader #(.RD_N(RD_N), .ID_W(ID_W), .TS_W(TS_W), .RIDX_W(RIDX_W)) u_rd (
    .clk(clk), .rst(rst), .head_valid(!q_empty),
    .head_id(q_head[QW-1:TS_W]), .head_ts(q_head[TS_W-1:0]),
    .pop(q_pop), .busy(rd_busy), .rel_en(rel_en), .rel_id(rel_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_seg(out_seg),
    .out_ts(out_ts), .out_idx(out_idx), .out_last(out_last)
  );

  assign data_ready = !q_empty || rd_busy;

  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> !q_full);

  assert_ovf_only_on_trig_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf_count) |-> $past(trig_in));

  assert_fill_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (st == WR_FILL && !push) |=> (st == WR_FILL && $stable(wid) && $stable(wts)));
endmodule

// File: tb/tb_segcap_top.sv
module tb_segcap_top;
  localparam int N_SEG = 4;
  localparam int RD_N  = 20;
  localparam int TSW   = 8;
  localparam int TSMOD = 1 << TSW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_in = 1'b0;
  logic       out_ready = 1'b0;
  logic       data_ready, out_valid, out_last;
  logic [7:0] ovf_count;
  logic [1:0] out_seg;
  logic [7:0] out_ts;
  logic [4:0] out_idx;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  segcap_top dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .data_ready(data_ready),
    .ovf_count(ovf_count), .out_valid(out_valid), .out_ready(out_ready),
    .out_seg(out_seg), .out_ts(out_ts), .out_idx(out_idx), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // call right after a negedge; trigger is seen on the following posedge
  task automatic pulse();
    trig_in = 1'b1;
    @(negedge clk);
    trig_in = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode 0: always ready, 1: alternating, 2: one in three
  task automatic read_event(input int mode, output int seg, output int ts);
    int beat = 0;
    int cyc = 0;
    bit prev_stall = 0;
    int pidx = 0, pseg = 0, pts = 0;
    bit done = 0;
    seg = -1; ts = -1;
    while (!done) begin
      @(negedge clk);
      if (prev_stall)
        check(out_valid && out_idx == pidx && out_seg == pseg && out_ts == pts,
              "R8", "beat held under stall idx", int'(out_idx), pidx);
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 2 == 1) : (cyc % 3 == 0);
      cyc++;
      if (out_valid) begin
        if (out_ready) begin
          check(out_idx == beat, "R7", "sample index", int'(out_idx), beat);
          check(out_last == (beat == RD_N - 1), "R7", "last flag", int'(out_last),
                int'(beat == RD_N - 1));
          if (beat == 0) begin
            seg = out_seg; ts = out_ts;
          end else begin
            check(out_seg == seg && out_ts == ts, "R7", "segment tag constant",
                  int'(out_seg), seg);
          end
          beat++;
          if (out_last || beat >= RD_N) done = 1;
        end
        prev_stall = !out_ready;
        pidx = out_idx; pseg = out_seg; pts = out_ts;
      end else begin
        prev_stall = 0;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(data_ready == 0, "R1", "data_ready after reset", int'(data_ready), 0);
    check(ovf_count == 0, "R1", "ovf_count after reset", int'(ovf_count), 0);
  endtask

  task automatic t_single_and_ignore();
    int s, t;
    pulse();
    idle(4);
    pulse();                 // during fill: must be ignored (R3)
    idle(26);                // now at 32nd negedge after trigger edge
    check(data_ready == 0, "R3", "not ready before fill ends", int'(data_ready), 0);
    idle(1);
    check(data_ready == 1, "R3", "ready after 32 cycles", int'(data_ready), 1);
    check(data_ready == 1, "R10", "flag with filled segment", int'(data_ready), 1);
    read_event(0, s, t);
    check(s == 0, "R2", "first segment number", s, 0);
    idle(3);
    check(data_ready == 0, "R3", "trigger during fill made no segment", int'(data_ready), 0);
    check(data_ready == 0, "R10", "flag clear when drained", int'(data_ready), 0);
    check(ovf_count == 0, "R3", "trigger during fill not counted", int'(ovf_count), 0);
  endtask

  task automatic t_timestamps(input int gap, input int mode);
    int sa, ta, sb, tb;
    pulse();
    idle(gap - 1);
    pulse();
    idle(40);
    read_event(mode, sa, ta);
    read_event(0, sb, tb);
    check(sa == 0, "R6", "older segment first", sa, 0);
    check(sb == 1, "R9", "claimed while other segment awaited readout", sb, 1);
    check(((tb - ta) % TSMOD + TSMOD) % TSMOD == gap % TSMOD, "R5",
          "timestamp difference", ((tb - ta) % TSMOD + TSMOD) % TSMOD, gap % TSMOD);
  endtask

  task automatic t_overflow_release();
    int s, t, t0;
    int exp_seg[4] = '{1, 2, 3, 0};
    for (int k = 0; k < 4; k++) begin
      pulse();
      idle(39);
    end
    idle(1);
    pulse();
    check(ovf_count == 1, "R4", "drop counted when pool full", int'(ovf_count), 1);
    idle(5);
    read_event(1, s, t0);
    check(s == 0, "R9", "first drained segment", s, 0);
    pulse();                 // seg 0 freed at its last beat
    check(ovf_count == 1, "R9", "freed segment reused without drop", int'(ovf_count), 1);
    idle(40);
    for (int k = 0; k < 4; k++) begin
      read_event(0, s, t);
      check(s == exp_seg[k], "R6", "queue order", s, exp_seg[k]);
      if (k < 3)
        check(((t - t0) % TSMOD + TSMOD) % TSMOD == 40 * (k + 1), "R5",
              "timestamp spacing", ((t - t0) % TSMOD + TSMOD) % TSMOD, 40 * (k + 1));
    end
    idle(2);
    check(data_ready == 0, "R10", "flag clear after full drain", int'(data_ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_single_and_ignore();
    t_timestamps(50, 2);
    t_timestamps(300, 1);
    t_overflow_release();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule